// File: doc/BRIEF.md
# Peripheral Address Region Decoder

This block sits behind a single memory-mapped I/O window and fans each bus request out to one of eleven peripheral register ports. A request carries a 19-bit byte offset, a read/write flag, write data and an access size. The upper offset bits pick a region. Each region derives its own local register index from a different slice of the offset. One select line rises for the chosen port, and the write data and the index are steered to it. On a read, the port's data is multiplexed back to the requester.

Three windows need special handling. The legacy serial window sends its lowest addresses through a small translation table. Its middle band is a hole that raises an error. Its upper band falls through to native serial addressing. The DMA register space is split into 256-byte channel windows, and only the channels named in a parameter mask are built. Accesses to any other channel are dropped, and a warning is raised only the first time each such channel is touched. Regions with nothing mapped behind them read as zero, ignore writes and pulse a warning.

Select, index, write data and all strobes are registered. Each result is therefore seen on the ports in the cycle after the request. The peripheral read data returns through a combinational multiplexer driven by the registered select.

Top module: `mmio_region_decoder`

## Requirements
- R1: The region number is `req_offset_i[18:12]`. A request drives at most one bit of `per_sel_o` high, in the cycle after the request. The bit positions are: 0 control, 1 DMA, 2 SCSI, 3 Ethernet, 4 serial, 5 sound, 6 floppy, 7 VIA-style port, 8 IDE0, 9 IDE1, 10 NVRAM.
- R2: Region 0x00 selects the control port and region 0x08 selects the DMA port. Both use index `offset[11:0]`, and the DMA channel is `offset[11:8]`.
- R3: The following regions use index `offset[7:4]`: SCSI (0x10), floppy (0x15) and native serial (0x13). IDE0 (0x20) and IDE1 (0x21) use index `offset[8:4]`.
- R4: Regions 0x16 and 0x17 both select the VIA-style port, with index `offset[12:9]`.
- R5: The Ethernet region 0x11 uses index `offset[11:0]`. Its write data and read data are byte-swapped according to `req_size_i`, as follows:
  - size 0: data unchanged.
  - size 1: the two low bytes are exchanged and the upper half becomes zero.
  - size 2 or 3: all four bytes are reversed.

  The sound region 0x14 uses index `offset[7:0]`.
- R6: In region 0x12, a low offset byte below 0x0C selects the serial port. Its index is `table[offset[4:1]]`, where the table maps 0→1, 1→3, 2→0, 3→2, 4→5, 5→7.
- R7: In region 0x12, a low byte from 0x0C to 0x5F selects nothing. A read there returns zero, a write is dropped, and `err_o` pulses for one cycle.
- R8: In region 0x12, a low byte of 0x60 or above selects the serial port with index `offset[7:4]`.
- R9: Any region from 0x60 upward selects NVRAM with index `offset[16:4]`.
- R10: Any other region selects nothing. A read there returns zero, a write is dropped, and `warn_o` pulses.
- R11: A DMA access to a channel whose bit is clear in `DMA_PRESENT` (default 0x0C8F) behaves as follows:
  - No port is selected, a read returns zero and a write is dropped.
  - `warn_o` pulses only on the first access to that channel after reset.
- R12: A read raises `rsp_valid_o` in the next cycle, with `rsp_rdata_o` taken from the selected port. A write raises no `rsp_valid_o`. A write raises `per_we_o` together with the select and presents the steered data on `per_wdata_o`.
- R13: While reset is held and until the first request, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_offset_i | input | 19 | Byte offset inside the I/O window |
| req_size_i | input | 2 | Access size: 0 byte, 1 half, 2/3 word |
| req_wdata_i | input | 32 | Write data |
| per_sel_o | output | 11 | One select per peripheral port |
| per_we_o | output | 1 | Write strobe for the selected port |
| per_idx_o | output | 13 | Local register index |
| per_wdata_o | output | 32 | Steered write data |
| per_rdata_i | input | 352 | Read data of all ports, port p at bits [32p+31:32p] |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_rdata_o | output | 32 | Read response data |
| err_o | output | 1 | Legacy serial hole was accessed |
| warn_o | output | 1 | Unmapped region, or first access to an absent DMA channel |

## Verification
Every result of this block comes one rising edge after its request. This covers the select, the index, the steered write data, the response valid, the multiplexed read data and both strobes. The bench therefore drives a request at a falling edge and samples all of these at the following falling edge. Requests run back to back. The sticky state of an absent DMA channel is thus tested by an access that arrives in the very next cycle, and the bench's own sticky copy is updated in the same order as the requests.

// File: rtl/mmio_dec_pkg.sv
package mmio_dec_pkg;

    localparam int OFF_W    = 19;
    localparam int REG_LSB  = 12;
    localparam int REG_W    = OFF_W - REG_LSB;
    localparam int IDX_W    = 13;
    localparam int DATA_W   = 32;
    localparam int DMA_CH_W = REG_LSB - 8;
    localparam int DMA_CH   = 1 << DMA_CH_W;

    typedef enum logic [3:0] {
        P_CTRL   = 4'd0,
        P_DMA    = 4'd1,
        P_SCSI   = 4'd2,
        P_ENET   = 4'd3,
        P_SERIAL = 4'd4,
        P_SOUND  = 4'd5,
        P_FLOPPY = 4'd6,
        P_VIA    = 4'd7,
        P_IDE0   = 4'd8,
        P_IDE1   = 4'd9,
        P_NVRAM  = 4'd10
    } port_e;

    localparam int NUM_PORTS = 11;

    typedef struct packed {
        logic [NUM_PORTS-1:0] sel;
        logic                 we;
        logic [IDX_W-1:0]     idx;
        logic [DATA_W-1:0]    wdata;
        logic                 rd;
        logic                 err;
        logic                 warn;
        logic [1:0]           size;
    } dec_state_t;

    // size 0: as is; size 1: swap low half, clear upper; else full reverse
    function automatic logic [DATA_W-1:0] swap_sized(input logic [DATA_W-1:0] d,
                                                     input logic [1:0] sz);
        logic [DATA_W-1:0] r;
        case (sz)
            2'd0:    r = d;
            2'd1:    r = {16'h0000, d[7:0], d[15:8]};
            default: r = {d[7:0], d[15:8], d[23:16], d[31:24]};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mmio_serial_remap.sv
module mmio_serial_remap #(
    parameter int          ENTRY_W = 4,
    parameter int          ENTRIES = 16,
    parameter logic [ENTRIES*ENTRY_W-1:0] TABLE = '0
) (
    input  logic [$clog2(ENTRIES)-1:0] slot_i,
    output logic [ENTRY_W-1:0]         reg_o
);
    logic [ENTRY_W-1:0] entry [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        assign entry[e] = TABLE[e*ENTRY_W +: ENTRY_W];
    end

    assign reg_o = entry[slot_i];
endmodule

// File: rtl/mmio_region_map.sv
module mmio_region_map
    import mmio_dec_pkg::*;
#(
    parameter logic [63:0] SERIAL_MAP = 64'h0000_0000_0075_2031
) (
    input  logic [OFF_W-1:0]    off_i,
    output logic                hit_o,
    output port_e               port_o,
    output logic [IDX_W-1:0]    idx_o,
    output logic                gap_o,
    output logic                unmapped_o,
    output logic                dma_o,
    output logic [DMA_CH_W-1:0] dma_ch_o
);
    logic [REG_W-1:0] region;
    logic [7:0]       lo;
    logic [3:0]       legacy_idx;

    assign region   = off_i[OFF_W-1:REG_LSB];
    assign lo       = off_i[7:0];
    assign dma_ch_o = off_i[REG_LSB-1:8];

    mmio_serial_remap #(
        .ENTRY_W(4),
        .ENTRIES(16),
        .TABLE  (SERIAL_MAP)
    ) u_remap (
        .slot_i(off_i[4:1]),
        .reg_o (legacy_idx)
    );

    always_comb begin
        hit_o      = 1'b1;
        port_o     = P_CTRL;
        idx_o      = '0;
        gap_o      = 1'b0;
        unmapped_o = 1'b0;
        dma_o      = 1'b0;
        if (region >= REG_W'(7'h60)) begin
            port_o = P_NVRAM;
            idx_o  = IDX_W'(off_i[16:4]);
        end else begin
            case (region)
                7'h00: begin port_o = P_CTRL;  idx_o = IDX_W'(off_i[11:0]); end
                7'h08: begin
                    port_o = P_DMA;
                    idx_o  = IDX_W'(off_i[11:0]);
                    dma_o  = 1'b1;
                end
                7'h10: begin port_o = P_SCSI;   idx_o = IDX_W'(off_i[7:4]);  end
                7'h11: begin port_o = P_ENET;   idx_o = IDX_W'(off_i[11:0]); end
                7'h12: begin
                    port_o = P_SERIAL;
                    if (lo < 8'h0C) begin
                        idx_o = IDX_W'(legacy_idx);
                    end else if (lo < 8'h60) begin
                        hit_o = 1'b0;
                        gap_o = 1'b1;
                    end else begin
                        idx_o = IDX_W'(off_i[7:4]);
                    end
                end
                7'h13: begin port_o = P_SERIAL; idx_o = IDX_W'(off_i[7:4]);  end
                7'h14: begin port_o = P_SOUND;  idx_o = IDX_W'(off_i[7:0]);  end
                7'h15: begin port_o = P_FLOPPY; idx_o = IDX_W'(off_i[7:4]);  end
                7'h16,
                7'h17: begin port_o = P_VIA;    idx_o = IDX_W'(off_i[12:9]); end
                7'h20: begin port_o = P_IDE0;   idx_o = IDX_W'(off_i[8:4]);  end
                7'h21: begin port_o = P_IDE1;   idx_o = IDX_W'(off_i[8:4]);  end
                default: begin
                    hit_o      = 1'b0;
                    unmapped_o = 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        assert_gap_excl_R7: assert (!(gap_o && (hit_o || unmapped_o)))
            else $error("serial hole also hit a port");
    end
endmodule

// File: rtl/mmio_dma_guard.sv
module mmio_dma_guard
    import mmio_dec_pkg::*;
#(
    parameter logic [DMA_CH-1:0] PRESENT = '1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_i,
    input  logic [DMA_CH_W-1:0] ch_i,
    output logic                allow_o,
    output logic                first_o
);
    logic [DMA_CH-1:0] sticky_d, sticky_q;

    assign allow_o = PRESENT[ch_i];
    assign first_o = acc_i && !PRESENT[ch_i] && !sticky_q[ch_i];

    always_comb begin
        sticky_d = sticky_q;
        if (first_o) sticky_d[ch_i] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= sticky_d;
    end

    assert_sticky_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(sticky_q) & ~sticky_q) == '0))
        else $error("unsupported-channel bit cleared");

    assert_first_marks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        first_o |=> sticky_q[$past(ch_i)])
        else $error("first access did not mark channel");

    assert_present_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_q & PRESENT) == '0)
        else $error("present channel marked unsupported");
endmodule

// File: rtl/mmio_region_decoder.sv
module mmio_region_decoder
    import mmio_dec_pkg::*;
#(
    parameter logic [DMA_CH-1:0] DMA_PRESENT = 16'h0C8F,
    parameter logic [63:0]       SERIAL_MAP  = 64'h0000_0000_0075_2031
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid_i,
    input  logic                          req_write_i,
    input  logic [OFF_W-1:0]              req_offset_i,
    input  logic [1:0]                    req_size_i,
    input  logic [DATA_W-1:0]             req_wdata_i,
    output logic [NUM_PORTS-1:0]          per_sel_o,
    output logic                          per_we_o,
    output logic [IDX_W-1:0]              per_idx_o,
    output logic [DATA_W-1:0]             per_wdata_o,
    input  logic [NUM_PORTS*DATA_W-1:0]   per_rdata_i,
    output logic                          rsp_valid_o,
    output logic [DATA_W-1:0]             rsp_rdata_o,
    output logic                          err_o,
    output logic                          warn_o
);
    dec_state_t d, q;

    logic                hit, gap, unmapped, is_dma, dma_allow, dma_first;
    port_e               port;
    logic [IDX_W-1:0]    idx;
    logic [DMA_CH_W-1:0] dma_ch;
    logic [DATA_W-1:0]   rd_raw;

    mmio_region_map #(.SERIAL_MAP(SERIAL_MAP)) u_map (
        .off_i     (req_offset_i),
        .hit_o     (hit),
        .port_o    (port),
        .idx_o     (idx),
        .gap_o     (gap),
        .unmapped_o(unmapped),
        .dma_o     (is_dma),
        .dma_ch_o  (dma_ch)
    );

    mmio_dma_guard #(.PRESENT(DMA_PRESENT)) u_guard (
        .clk    (clk),
        .rst_n  (rst_n),
        .acc_i  (req_valid_i && is_dma),
        .ch_i   (dma_ch),
        .allow_o(dma_allow),
        .first_o(dma_first)
    );

    always_comb begin
        d       = '0;
        d.size  = req_size_i;
        d.idx   = idx;
        d.we    = req_valid_i && req_write_i;
        d.rd    = req_valid_i && !req_write_i;
        d.err   = req_valid_i && gap;
        d.warn  = req_valid_i && (unmapped || dma_first);
        d.wdata = (port == P_ENET) ? swap_sized(req_wdata_i, req_size_i) : req_wdata_i;
        if (req_valid_i && hit && (!is_dma || dma_allow))
            d.sel[port] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rd_raw = '0;
        for (int p = 0; p < NUM_PORTS; p++)
            if (q.sel[p]) rd_raw = rd_raw | per_rdata_i[p*DATA_W +: DATA_W];
    end

    assign per_sel_o   = q.sel;
    assign per_we_o    = q.we && (|q.sel);
    assign per_idx_o   = q.idx;
    assign per_wdata_o = q.wdata;
    assign rsp_valid_o = q.rd;
    assign err_o       = q.err;
    assign warn_o      = q.warn;
    assign rsp_rdata_o = !q.rd ? '0 :
                         q.sel[int'(P_ENET)] ? swap_sized(rd_raw, q.size) : rd_raw;

    assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(per_sel_o))
        else $error("more than one select");

    assert_sel_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid_i) |-> per_sel_o == '0)
        else $error("select without request");

    assert_hole_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (per_sel_o == '0 && !per_we_o))
        else $error("serial hole reached a port");

    assert_nvram_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid_i && req_offset_i[OFF_W-1:OFF_W-2] == 2'b11)
        |-> per_sel_o[int'(P_NVRAM)])
        else $error("upper window missed NVRAM");

    assert_unsel_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && per_sel_o == '0) |-> rsp_rdata_o == '0)
        else $error("unselected read not zero");

    assert_resp_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> !per_we_o)
        else $error("response on a write");
endmodule

// File: tb/mmio_region_decoder_bench.sv
module mmio_region_decoder_bench;
    import mmio_dec_pkg::*;

    localparam logic [15:0] PRESENT = 16'h0C8F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [18:0] req_offset = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic [10:0] per_sel;
    logic        per_we;
    logic [12:0] per_idx;
    logic [31:0] per_wdata;
    logic [351:0] per_rdata;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        err, warn;

    int          tests = 0, fails = 0;
    logic [15:0] bsticky = '0;
    bit          done = 0;

    always #10 clk = ~clk;

    mmio_region_decoder u_mmio_region_decoder (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_write_i(req_write),
        .req_offset_i(req_offset), .req_size_i(req_size), .req_wdata_i(req_wdata),
        .per_sel_o(per_sel), .per_we_o(per_we), .per_idx_o(per_idx),
        .per_wdata_o(per_wdata), .per_rdata_i(per_rdata),
        .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
        .err_o(err), .warn_o(warn)
    );

    // register stubs: each port answers with its number and the index it sees
    for (genvar p = 0; p < 11; p++) begin : g_stub
        assign per_rdata[p*32 +: 32] = {4'(p), 15'd0, per_idx};
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [3:0] remap(input logic [3:0] i);
        case (i)
            4'd0: return 4'd1;
            4'd1: return 4'd3;
            4'd2: return 4'd0;
            4'd3: return 4'd2;
            4'd4: return 4'd5;
            4'd5: return 4'd7;
            default: return 4'd0;
        endcase
    endfunction

    function automatic logic [31:0] bswap(input logic [31:0] d, input logic [1:0] sz);
        if (sz == 2'd0) return d;
        if (sz == 2'd1) return {16'h0000, d[7:0], d[15:8]};
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    task automatic model(input logic [18:0] off, output int port, output logic [12:0] idx,
                         output logic e, output logic w, output string tag);
        logic [6:0] rg;
        logic [7:0] lo;
        logic [3:0] ch;
        rg = off[18:12]; lo = off[7:0]; ch = off[11:8];
        port = -1; idx = '0; e = 0; w = 0; tag = "R10";
        if (rg >= 7'h60) begin port = 10; idx = off[16:4]; tag = "R9"; end
        else case (rg)
            7'h00: begin port = 0; idx = 13'(off[11:0]); tag = "R2"; end
            7'h08: begin
                if (PRESENT[ch]) begin port = 1; idx = 13'(off[11:0]); tag = "R2"; end
                else begin
                    tag = "R11";
                    w = !bsticky[ch];
                    bsticky[ch] = 1'b1;
                end
            end
            7'h10: begin port = 2; idx = 13'(off[7:4]); tag = "R3"; end
            7'h11: begin port = 3; idx = 13'(off[11:0]); tag = "R5"; end
            7'h12: begin
                if (lo < 8'h0C) begin port = 4; idx = 13'(remap(off[4:1])); tag = "R6"; end
                else if (lo < 8'h60) begin e = 1; tag = "R7"; end
                else begin port = 4; idx = 13'(off[7:4]); tag = "R8"; end
            end
            7'h13: begin port = 4; idx = 13'(off[7:4]); tag = "R3"; end
            7'h14: begin port = 5; idx = 13'(off[7:0]); tag = "R5"; end
            7'h15: begin port = 6; idx = 13'(off[7:4]); tag = "R3"; end
            7'h16, 7'h17: begin port = 7; idx = 13'(off[12:9]); tag = "R4"; end
            7'h20: begin port = 8; idx = 13'(off[8:4]); tag = "R3"; end
            7'h21: begin port = 9; idx = 13'(off[8:4]); tag = "R3"; end
            default: begin w = 1; tag = "R10"; end
        endcase
    endtask

    // drive at a falling edge, sample at the next falling edge (one rising edge later)
    task automatic do_req(input logic [18:0] off, input logic wr,
                          input logic [1:0] sz, input logic [31:0] wd);
        int          port;
        logic [12:0] idx;
        logic        e, w;
        string       tag;
        logic [10:0] esel;
        logic [31:0] stub, erd;
        model(off, port, idx, e, w, tag);
        req_valid = 1'b1; req_write = wr; req_offset = off; req_size = sz; req_wdata = wd;
        @(negedge clk);
        esel = (port >= 0) ? 11'(1 << port) : '0;
        check(per_sel == esel, tag, "select (R1)", 32'(per_sel), 32'(esel));
        if (port >= 0) check(per_idx == idx, tag, "index", 32'(per_idx), 32'(idx));
        check(per_we == (wr && port >= 0), tag, "write strobe R12", 32'(per_we),
              32'(wr && port >= 0));
        if (wr && port >= 0) begin
            erd = (port == 3) ? bswap(wd, sz) : wd;
            check(per_wdata == erd, tag, "write data", per_wdata, erd);
        end
        check(rsp_valid == !wr, "R12", "response valid", 32'(rsp_valid), 32'(!wr));
        if (!wr) begin
            stub = {4'(port), 15'd0, idx};
            erd  = (port < 0) ? 32'h0 : (port == 3) ? bswap(stub, sz) : stub;
            check(rsp_rdata == erd, tag, "read data", rsp_rdata, erd);
        end
        check(err == e, tag, "error strobe", 32'(err), 32'(e));
        check(warn == w, tag, "warning strobe", 32'(warn), 32'(w));
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [6:0]  rg;
        logic [18:0] off;
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        // R13: reset state
        check({per_sel, per_we, per_idx, per_wdata, rsp_valid, rsp_rdata, err, warn} == '0,
              "R13", "outputs in reset", 32'(per_sel), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check({per_sel, per_we, rsp_valid, err, warn} == '0, "R13", "idle after reset",
              32'(per_sel), 32'h0);

        // directed corners
        do_req(19'h00_0A4, 1'b0, 2'd2, 32'h0);            // R2 control
        do_req(19'h08_0F8, 1'b1, 2'd2, 32'h1234_5678);    // R2 DMA ch0 present
        do_req(19'h08_410, 1'b0, 2'd2, 32'h0);            // R11 ch4 absent, first
        do_req(19'h08_420, 1'b1, 2'd2, 32'hDEAD_BEEF);    // R11 ch4 again, no warn
        do_req(19'h08_B00, 1'b0, 2'd2, 32'h0);            // R11 ch11 present
        do_req(19'h10_0F0, 1'b0, 2'd0, 32'h0);            // R3 SCSI
        do_req(19'h11_ABC, 1'b0, 2'd0, 32'h0);            // R5 enet byte
        do_req(19'h11_ABC, 1'b0, 2'd1, 32'h0);            // R5 enet half
        do_req(19'h11_ABC, 1'b1, 2'd2, 32'hA1B2_C3D4);    // R5 enet word write
        do_req(19'h11_002, 1'b1, 2'd1, 32'hA1B2_C3D4);    // R5 enet half write
        do_req(19'h14_0FF, 1'b0, 2'd0, 32'h0);            // R5 sound
        do_req(19'h12_000, 1'b1, 2'd0, 32'h0000_0055);    // R6 table slot 0
        do_req(19'h12_00B, 1'b0, 2'd0, 32'h0);            // R6 last remapped
        do_req(19'h12_00C, 1'b0, 2'd0, 32'h0);            // R7 hole start
        do_req(19'h12_05F, 1'b1, 2'd0, 32'hFFFF_FFFF);    // R7 hole end, write dropped
        do_req(19'h12_060, 1'b0, 2'd0, 32'h0);            // R8 native fallthrough
        do_req(19'h13_0F0, 1'b0, 2'd0, 32'h0);            // R3 native serial
        do_req(19'h16_200, 1'b0, 2'd0, 32'h0);            // R4 VIA
        do_req(19'h17_E00, 1'b0, 2'd0, 32'h0);            // R4 VIA alias
        do_req(19'h20_1F0, 1'b0, 2'd1, 32'h0);            // R3 IDE0
        do_req(19'h21_010, 1'b1, 2'd1, 32'h0000_00AA);    // R3 IDE1
        do_req(19'h60_000, 1'b0, 2'd0, 32'h0);            // R9 NVRAM low
        do_req(19'h7F_FF0, 1'b1, 2'd0, 32'h0000_0042);    // R9 NVRAM top
        do_req(19'h01_000, 1'b0, 2'd2, 32'h0);            // R10 unmapped
        do_req(19'h5F_FFC, 1'b1, 2'd2, 32'h0BAD_0BAD);    // R10 unmapped write
        req_valid = 1'b0;
        @(negedge clk);
        check(per_sel == '0 && !rsp_valid, "R1", "idle gap", 32'(per_sel), 32'h0);

        // constrained random
        for (int n = 0; n < 800; n++) begin
            case ($urandom_range(0, 14))
                0:  rg = 7'h00;
                1:  rg = 7'h08;
                2:  rg = 7'h08;
                3:  rg = 7'h10;
                4:  rg = 7'h11;
                5:  rg = 7'h12;
                6:  rg = 7'h12;
                7:  rg = 7'h13;
                8:  rg = 7'h14;
                9:  rg = 7'h15;
                10: rg = 7'(16 + 6 + $urandom_range(0, 1));
                11: rg = 7'(32 + $urandom_range(0, 1));
                12: rg = 7'($urandom_range(96, 127));
                default: rg = 7'($urandom_range(0, 95));
            endcase
            off = {rg, 12'($urandom)};
            if (rg == 7'h12 && $urandom_range(0, 1) == 1)
                off[7:0] = 8'($urandom_range(0, 11));
            do_req(off, 1'($urandom), 2'($urandom), $urandom);
            if ($urandom_range(0, 7) == 0) begin
                req_valid = 1'b0;
                @(negedge clk);
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule